// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a memory with two independent access ports, here called left and right. Each clock cycle it compares what the two ports present. When both are enabled and both point at the same location, it lets one of them continue. The other is told it is busy, and any write from that busy side is suppressed. Only the enables and the addresses take part in the decision. Whether a port reads or writes does not change who wins.

The block runs in one of two modes, chosen by a pin. In master mode it makes the decision itself and drives active-low busy outputs. In slave mode its own busy outputs stay inactive and it takes active-low busy inputs instead. It then uses those inputs only to block writes from the matching port. This lets one master's decision control the write blocking of several memories placed side by side to form a wider word.

Every output is registered, so the busy flags and the gated write strobes change only at clock edges and cannot glitch. The write gating is computed from the same cycle's decision as the busy flag, so a write can never pass ahead of its own busy indication. A combined collision flag can be used as an error interrupt source.

Top module: `dual_port_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, both busy outputs are 1, both gated write strobes are 0, and the collision output is 0.
- R2: All outputs are registered. The values presented in one cycle show on the outputs after the next rising clock edge. In master mode the two busy outputs are never 0 together.
- R3: In master mode, a collision occurs when both enables are 1 and the two addresses are equal. If neither port was enabled at that same address in the previous cycle, the left port wins. The result is right busy = 0 and left busy = 1.
- R4: In master mode, if exactly one port was already enabled at the colliding address in the previous cycle, that port keeps priority and the other port is flagged busy. A winner that holds its address keeps winning for as long as the collision lasts.
- R5: The busy side's gated write strobe is 0 even when that port requests a write. The winning side's gated write strobe equals its enable AND its write request.
- R6: Arbitration does not depend on the write request inputs. A read-only winner still wins against a writing loser.
- R7: When the winner changes its address or drops its enable, the busy output goes back to 1 on the next output update.
- R8: Without a collision (addresses differ, or either enable is 0), both busy outputs are 1. Each gated write strobe equals that port's enable AND its write request, so a disabled port never writes.
- R9: In slave mode (slave mode pin = 1), both busy outputs stay 1 whatever the addresses are. Each port's gated write strobe is its enable AND its write request AND its active-low busy input.
- R10: The collision output is 1 exactly when a busy indication is active. In master mode that means either busy output is 0. In slave mode it means either busy input was 0 in the cycle that produced the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slaveMode | input | 1 | 1 = slave: busy inputs only block writes; 0 = master |
| lEn | input | 1 | Left port enable |
| lAddr | input | ADDR_W | Left port address |
| lWrEn | input | 1 | Left port write request |
| rEn | input | 1 | Right port enable |
| rAddr | input | ADDR_W | Right port address |
| rWrEn | input | 1 | Right port write request |
| lBusyInN | input | 1 | Active-low busy input for the left port, used in slave mode |
| rBusyInN | input | 1 | Active-low busy input for the right port, used in slave mode |
| lBusyN | output | 1 | Active-low busy output for the left port |
| rBusyN | output | 1 | Active-low busy output for the right port |
| lWrGated | output | 1 | Left write strobe after gating |
| rWrGated | output | 1 | Right write strobe after gating |
| collision | output | 1 | 1 while any busy indication is active |

## Verification
Address pairs that differ are run against equal pairs, so that a real match can be told apart from mere activity on both ports. Collisions that start on both ports in the same cycle are contrasted with collisions where one port was already parked on the location, which separates the left-wins default from the incumbent rule. Read-only and writing combinations are applied to the same collisions to show that the write requests play no part in the decision. Slave-mode runs with each busy input pattern confirm that the pattern alone selects which writes are blocked, even while the addresses collide.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_LEFT  = 2'd1,
    WIN_RIGHT = 2'd2
  } winner_e;

  // comparison results passed from datapath to control
  typedef struct packed {
    logic sameNow;   // both enabled at the same address this cycle
    logic lHeld;     // left enabled at this address last cycle too
    logic rHeld;     // right enabled at this address last cycle too
  } matchFlags_t;

  // strobes passed from control to datapath
  typedef struct packed {
    logic lBusy;
    logic rBusy;
    logic lBlock;
    logic rBlock;
  } arbStrobes_t;

endpackage

// File: rtl/dpa_datapath.sv
module dpa_datapath
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lEn,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lWrEn,
  input  logic              rEn,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rWrEn,
  input  arbStrobes_t       strobes,
  output matchFlags_t       flags,
  output logic              lBusyN,
  output logic              rBusyN,
  output logic              lWrGated,
  output logic              rWrGated,
  output logic              collision
);

  localparam logic [ADDR_W-1:0] ADDR_ZERO = '0;

  logic              prevLEn;
  logic              prevREn;
  logic [ADDR_W-1:0] prevLAddr;
  logic [ADDR_W-1:0] prevRAddr;

  // history of what each port presented one cycle ago
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLEn   <= 1'b0;
      prevREn   <= 1'b0;
      prevLAddr <= ADDR_ZERO;
      prevRAddr <= ADDR_ZERO;
    end else begin
      prevLEn   <= lEn;
      prevREn   <= rEn;
      prevLAddr <= lAddr;
      prevRAddr <= rAddr;
    end
  end

  always_comb begin
    flags.sameNow = lEn && rEn && (lAddr == rAddr);
    flags.lHeld   = lEn && prevLEn && (prevLAddr == lAddr);
    flags.rHeld   = rEn && prevREn && (prevRAddr == rAddr);
  end

  // registered outputs: flags and gated strobes from the same decision
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lBusyN    <= 1'b1;
      rBusyN    <= 1'b1;
      lWrGated  <= 1'b0;
      rWrGated  <= 1'b0;
      collision <= 1'b0;
    end else begin
      lBusyN    <= !strobes.lBusy;
      rBusyN    <= !strobes.rBusy;
      lWrGated  <= lEn && lWrEn && !strobes.lBlock;
      rWrGated  <= rEn && rWrEn && !strobes.rBlock;
      collision <= strobes.lBlock || strobes.rBlock;
    end
  end

endmodule

// File: rtl/dpa_ctrl.sv
module dpa_ctrl
  import dpa_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        slaveMode,
  input  logic        lBusyInN,
  input  logic        rBusyInN,
  input  matchFlags_t flags,
  output arbStrobes_t strobes
);

  winner_e winReg;
  winner_e winNext;

  always_comb begin
    winNext = WIN_NONE;
    if (!slaveMode && flags.sameNow) begin
      if (winReg == WIN_LEFT && flags.lHeld)
        winNext = WIN_LEFT;
      else if (winReg == WIN_RIGHT && flags.rHeld)
        winNext = WIN_RIGHT;
      else if (flags.rHeld && !flags.lHeld)
        winNext = WIN_RIGHT;
      else
        winNext = WIN_LEFT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) winReg <= WIN_NONE;
    else       winReg <= winNext;
  end

  always_comb begin
    strobes.lBusy  = (winNext == WIN_RIGHT);
    strobes.rBusy  = (winNext == WIN_LEFT);
    strobes.lBlock = slaveMode ? !lBusyInN : strobes.lBusy;
    strobes.rBlock = slaveMode ? !rBusyInN : strobes.rBusy;
  end

endmodule

// File: rtl/dual_port_arbiter.sv
module dual_port_arbiter
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              lEn,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lWrEn,
  input  logic              rEn,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rWrEn,
  input  logic              lBusyInN,
  input  logic              rBusyInN,
  output logic              lBusyN,
  output logic              rBusyN,
  output logic              lWrGated,
  output logic              rWrGated,
  output logic              collision
);

  matchFlags_t flags;
  arbStrobes_t strobes;

  dpa_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .slaveMode(slaveMode),
    .lBusyInN (lBusyInN),
    .rBusyInN (rBusyInN),
    .flags    (flags),
    .strobes  (strobes)
  );

  dpa_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .lEn      (lEn),
    .lAddr    (lAddr),
    .lWrEn    (lWrEn),
    .rEn      (rEn),
    .rAddr    (rAddr),
    .rWrEn    (rWrEn),
    .strobes  (strobes),
    .flags    (flags),
    .lBusyN   (lBusyN),
    .rBusyN   (rBusyN),
    .lWrGated (lWrGated),
    .rWrGated (rWrGated),
    .collision(collision)
  );

endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              slaveMode,
  input logic              lEn,
  input logic [ADDR_W-1:0] lAddr,
  input logic              lWrEn,
  input logic              rEn,
  input logic [ADDR_W-1:0] rAddr,
  input logic              lBusyInN,
  input logic              lBusyN,
  input logic              rBusyN,
  input logic              lWrGated,
  input logic              rWrGated,
  input logic              collision
);

  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!lBusyN && !rBusyN)); // R2

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && lEn && rEn && lAddr == rAddr) |=> !(lWrGated && rWrGated)); // R5

  AST_FREE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && !(lEn && rEn && lAddr == rAddr))
      |=> (lBusyN && rBusyN && !collision)); // R8

  AST_FREE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && lEn && lWrEn && !(rEn && lAddr == rAddr)) |=> lWrGated); // R8

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    slaveMode |=> (lBusyN && rBusyN)); // R9

  AST_SLAVE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (slaveMode && !lBusyInN) |=> (!lWrGated && collision)); // R9

  AST_COLL_OR: assert property (@(posedge clk) disable iff (!rstN)
    !slaveMode |=> (collision == (!lBusyN || !rBusyN))); // R10

endmodule

bind dual_port_arbiter dpa_checker #(.ADDR_W(ADDR_W)) i_dpa_checker (
  .clk      (clk),
  .rstN     (rstN),
  .slaveMode(slaveMode),
  .lEn      (lEn),
  .lAddr    (lAddr),
  .lWrEn    (lWrEn),
  .rEn      (rEn),
  .rAddr    (rAddr),
  .lBusyInN (lBusyInN),
  .lBusyN   (lBusyN),
  .rBusyN   (rBusyN),
  .lWrGated (lWrGated),
  .rWrGated (rWrGated),
  .collision(collision)
);

// File: tb/test_dual_port_arbiter.sv
module test_dual_port_arbiter;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          slaveMode = 1'b0;
  logic          lEn = 1'b0, rEn = 1'b0, lWrEn = 1'b0, rWrEn = 1'b0;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic          lBusyInN = 1'b1, rBusyInN = 1'b1;
  logic          lBusyN, rBusyN, lWrGated, rWrGated, collision;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [4:0] exp;   // {lBusyN, rBusyN, lWrGated, rWrGated, collision}
    string      tag;
  } expItem_t;

  expItem_t scoreQ[$];

  always #2 clk = ~clk;   // 250 MHz

  dual_port_arbiter #(.ADDR_W(AW)) i_dual_port_arbiter (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .lEn(lEn), .lAddr(lAddr), .lWrEn(lWrEn),
    .rEn(rEn), .rAddr(rAddr), .rWrEn(rWrEn),
    .lBusyInN(lBusyInN), .rBusyInN(rBusyInN),
    .lBusyN(lBusyN), .rBusyN(rBusyN),
    .lWrGated(lWrGated), .rWrGated(rWrGated), .collision(collision)
  );

  function automatic logic [4:0] outVec();
    return {lBusyN, rBusyN, lWrGated, rWrGated, collision};
  endfunction

  task automatic checkNow(input logic [4:0] exp, input string tag);
    testsRun++;
    if (outVec() !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %b expected %b", tag, outVec(), exp);
    end
  endtask

  // driver: apply one cycle of stimulus at the falling edge and queue the result
  task automatic step(input logic le, input int la, input logic lw,
                      input logic re, input int ra, input logic rw,
                      input logic [4:0] exp, input string tag);
    expItem_t it;
    @(negedge clk);
    lEn = le; lAddr = AW'(la); lWrEn = lw;
    rEn = re; rAddr = AW'(ra); rWrEn = rw;
    it.exp = exp;
    it.tag = tag;
    scoreQ.push_back(it);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scoreQ.size() > 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        checkNow(it.exp, it.tag);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkNow(5'b11000, "R1 during reset");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    checkNow(5'b11000, "R1 after reset");

    // master mode; output bits are {lBusyN, rBusyN, lWrGated, rWrGated, collision}
    step(1, 5, 1, 1, 9, 1, 5'b11110, "R8 different addresses");
    step(1, 7, 1, 1, 7, 1, 5'b10101, "R3 simultaneous start left wins");
    step(1, 7, 1, 1, 7, 1, 5'b10101, "R2 collision held");
    step(1, 8, 1, 1, 7, 1, 5'b11110, "R7 winner moves away");
    step(1, 7, 1, 1, 7, 1, 5'b01011, "R4 right incumbent wins");
    step(1, 7, 0, 1, 7, 0, 5'b01001, "R6 reads keep same winner");
    step(1, 7, 1, 0, 7, 1, 5'b11100, "R7 winner drops enable");
    step(1, 3, 0, 1, 3, 1, 5'b10001, "R6 read-only left beats writer");
    step(1, 3, 0, 0, 3, 1, 5'b11000, "R8 disabled port no write");
    step(1, 3, 0, 1, 3, 1, 5'b10001, "R4 left incumbent");
    step(1, 4, 1, 1, 4, 1, 5'b10101, "R3 both move together");
    step(1, 1023, 1, 1, 1023, 1, 5'b10101, "R5 top address loser blocked");
    step(0, 1023, 1, 1, 1023, 1, 5'b11010, "R7 left disabled");
    step(1, 1023, 1, 1, 1023, 1, 5'b01011, "R4 right incumbent top address");
    step(1, 0, 1, 1, 1023, 0, 5'b11100, "R10 collision drops");

    // slave mode
    @(negedge clk);
    slaveMode = 1'b1;
    step(1, 6, 1, 1, 6, 1, 5'b11110, "R9 slave inactive busy inputs");
    @(negedge clk);
    lBusyInN = 1'b0;
    step(1, 6, 1, 1, 6, 1, 5'b11011, "R9 slave left inhibited");
    @(negedge clk);
    lBusyInN = 1'b1; rBusyInN = 1'b0;
    step(1, 2, 1, 1, 6, 1, 5'b11101, "R10 slave right inhibited");
    @(negedge clk);
    lBusyInN = 1'b0;
    step(1, 2, 1, 1, 6, 1, 5'b11001, "R9 slave both inhibited");

    // back to master
    @(negedge clk);
    slaveMode = 1'b0; lBusyInN = 1'b1; rBusyInN = 1'b1;
    step(1, 11, 1, 1, 12, 1, 5'b11110, "R8 master again");
    step(1, 12, 1, 1, 12, 0, 5'b01001, "R4 right holds address");

    repeat (3) @(posedge clk);
    #1;
    finish();
  end

endmodule